// File: doc/BRIEF.md
# Gated Auto-Reload Baud Timer

This block produces the bit-rate tick for a serial port from an 8-bit timer that reloads itself. The timer advances on one of two sources: a free-running prescaler that gives one pulse every six clocks, or falling edges on an external event pin. A run bit enables counting. A gate option can also make counting depend on an active-low external pin.

When the count passes 0xFF, the counter loads a CPU-supplied reload byte and an overflow is raised. A rate-doubling bit decides what happens to each overflow. It is either sent on directly or passed through a toggle flop, so that only every second overflow reaches the output. The result is a single-clock tick that the serial port uses as its baud timing.

Top module: `baud_timer_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, baud_tick_o is 0; reset clears the counter to 0x00, the prescaler phase and the halving flop.
- R2: With run_i = 0 the counter holds its value and no tick is produced.
- R3: With gate_en_i = 1, counting is allowed only while gate_n_i is low (after a two-flop synchroniser). With gate_en_i = 0, the level on gate_n_i has no effect.
- R4: With src_sel_i = 0 the counter advances once every 6 clocks, paced by a free-running prescaler.
- R5: With src_sel_i = 1 the counter advances once per falling edge of evt_pin_i, measured after a two-flop synchroniser. Rising edges do not advance it.
- R6: An advance from 0xFF reloads the counter with reload_i and raises an overflow. Any other advance adds one. The tick period is therefore (256 − reload_i) advances per overflow.
- R7: With dbl_i = 1 every overflow produces a tick. With dbl_i = 0 a halving flop toggles on each overflow and only every second overflow produces a tick.
- R8: baud_tick_o is registered. It rises the clock after the qualifying overflow and is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable |
| gate_en_i | input | 1 | When 1, counting also needs gate_n_i low |
| src_sel_i | input | 1 | 0: prescaler by six, 1: external event pin |
| gate_n_i | input | 1 | External gate pin, active low, asynchronous |
| evt_pin_i | input | 1 | External event pin, counted on falling edges |
| dbl_i | input | 1 | 1: tick on every overflow, 0: every second overflow |
| reload_i | input | 8 | Reload value loaded on overflow |
| baud_tick_o | output | 1 | One-clock baud tick |

## Verification
Every internal state shows up at the tick output. A wrong counter, reload value or prescaler phase changes the spacing between ticks within one tick period. A halving flop with the wrong phase moves the first tick by a whole overflow interval. A broken gate or run qualifier gives ticks in windows where none should appear. A reference model in the bench, driven by the same inputs, is compared with baud_tick_o on every clock, so any of these errors is caught at the first cycle where the outputs differ. Directed measurements of the tick period confirm the same behaviour from the requirements' formulas.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
  localparam int unsigned CNT_W       = 8;
  localparam int unsigned PRE_DIV     = 6;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    SRC_PRESCALE = 1'b0,
    SRC_PIN      = 1'b1
  } src_sel_e;
endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= RST_VAL;
    else         sync_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= RST_VAL;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/bt_prescale.sv
module bt_prescale #(
  parameter int unsigned DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                  ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == LAST);
endmodule

// File: rtl/bt_reload_cnt.sv
module bt_reload_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = inc_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ovf_o) cnt_q <= reload_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bt_rate_sel.sv
module bt_rate_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic dbl_i,
  output logic half_o,
  output logic tick_o
);
  logic half_q, tick_q, tick_d;

  // halving path fires on the overflow that returns the toggle to 0
  assign tick_d = ovf_i && (dbl_i || half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (ovf_i) half_q <= ~half_q;
      tick_q <= tick_d;
    end
  end

  assign half_o = half_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/baud_timer_top.sv
module baud_timer_top
  import baud_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             gate_en_i,
  input  logic             src_sel_i,
  input  logic             gate_n_i,
  input  logic             evt_pin_i,
  input  logic             dbl_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             baud_tick_o
);
  logic gate_n_s, evt_s, evt_d, evt_fall;
  logic pre_tick, src_tick, gate_ok, inc, ovf, half_q;
  logic [CNT_W-1:0] cnt_q;
  src_sel_e src;

  bt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_n_i), .q_o(gate_n_s)
  );

  bt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_evt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_pin_i), .q_o(evt_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_d <= 1'b0;
    else         evt_d <= evt_s;
  end

  assign evt_fall = evt_d & ~evt_s;

  bt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(pre_tick)
  );

  assign src      = src_sel_e'(src_sel_i);
  assign src_tick = (src == SRC_PIN) ? evt_fall : pre_tick;
  assign gate_ok  = ~gate_en_i | ~gate_n_s;
  assign inc      = run_i & gate_ok & src_tick;

  bt_reload_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .reload_i(reload_i),
    .cnt_o(cnt_q), .ovf_o(ovf)
  );

  bt_rate_sel u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovf_i(ovf), .dbl_i(dbl_i),
    .half_o(half_q), .tick_o(baud_tick_o)
  );
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic         src_sel_i,
  input logic         dbl_i,
  input logic [W-1:0] reload_i,
  input logic         inc_i,
  input logic         ovf_i,
  input logic         half_i,
  input logic [W-1:0] cnt_i,
  input logic         tick_i
);
  // R8
  tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);

  // R2
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_i == $past(cnt_i));

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> cnt_i == $past(reload_i));

  // R7
  dbl_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && dbl_i) |=> tick_i);

  // R7
  half_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !dbl_i && !half_i) |=> (!tick_i && half_i));

  // R4
  pre_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !src_sel_i) |=> !inc_i);
endmodule

bind baud_timer_top bt_checker #(.W(baud_timer_pkg::CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .src_sel_i(src_sel_i),
  .dbl_i(dbl_i), .reload_i(reload_i), .inc_i(inc), .ovf_i(ovf),
  .half_i(half_q), .cnt_i(cnt_q), .tick_i(baud_tick_o)
);

// File: tb/tb_baud_timer_top.sv
`timescale 1ns/1ps
module tb_baud_timer_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, gate_en = 1'b0, src = 1'b0, gate_n = 1'b1, evt = 1'b0, dbl = 1'b1;
  logic [7:0] reload = 8'h00;
  logic tick;

  int checks = 0, failures = 0, cyc = 0;
  int pin_period = 0, pin_phase = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  baud_timer_top dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .gate_en_i(gate_en),
    .src_sel_i(src), .gate_n_i(gate_n), .evt_pin_i(evt), .dbl_i(dbl),
    .reload_i(reload), .baud_tick_o(tick)
  );

  // behavioural reference
  int m_g1 = 1, m_g2 = 1, m_e1 = 0, m_e2 = 0, m_e3 = 0;
  int m_pre = 0, m_cnt = 0, m_half = 0, m_tick = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_g1 = 1; m_g2 = 1; m_e1 = 0; m_e2 = 0; m_e3 = 0;
      m_pre = 0; m_cnt = 0; m_half = 0; m_tick = 0;
    end else begin
      bit step, wrap, fall, pre_ev, open;
      fall   = (m_e3 == 1) && (m_e2 == 0);
      pre_ev = (m_pre == 5);
      open   = !gate_en || (m_g2 == 0);
      step   = run && open && (src ? fall : pre_ev);
      wrap   = step && (m_cnt == 255);
      m_tick = (wrap && (dbl || m_half == 1)) ? 1 : 0;
      if (wrap) begin m_cnt = int'(reload); m_half = 1 - m_half; end
      else if (step) m_cnt = m_cnt + 1;
      m_pre = (m_pre + 1) % 6;
      m_e3 = m_e2; m_e2 = m_e1; m_e1 = int'(evt);
      m_g2 = m_g1; m_g1 = int'(gate_n);
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // external event pin pattern, driven away from the active edge
  always @(negedge clk) begin
    if (pin_period > 0) begin
      pin_phase = (pin_phase + 1) % pin_period;
      evt = (pin_phase < pin_period / 2);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) check(int'(tick) == m_tick, "R8 model", int'(tick), m_tick);
  end

  task automatic wait_tick(output bit got);
    int n = 0;
    got = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 6000);
    got = tick;
  endtask

  task automatic measure(input int exp, input string req);
    bit g;
    int t0;
    wait_tick(g);
    wait_tick(g);
    t0 = cyc;
    wait_tick(g);
    check(g && (cyc - t0 == exp), req, cyc - t0, exp);
    @(negedge clk);
    check(tick == 1'b0, "R8 width", int'(tick), 0);
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 in reset", int'(tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tick == 1'b0, "R1 after reset", int'(tick), 0);

    // R4 R6 R7: prescaler source, tick on every overflow
    reload = 8'hF0; run = 1'b1; dbl = 1'b1;
    measure(16 * 6, "R4 R6 dbl=1");
    reload = 8'hFA;
    measure(6 * 6, "R6 reload FA");
    // R7: halved
    dbl = 1'b0;
    measure(6 * 6 * 2, "R7 dbl=0");

    // R5: falling edges of the event pin
    dbl = 1'b1; reload = 8'hFC; src = 1'b1; pin_period = 4;
    measure(4 * 4, "R5 pin fall");
    pin_period = 10;
    measure(4 * 10, "R5 pin slow");
    dbl = 1'b0;
    measure(4 * 10 * 2, "R5 R7 pin halved");
    dbl = 1'b1; pin_period = 4;

    // R3: gate
    gate_en = 1'b1; gate_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet(1500, "R3 gate closed");
    gate_n = 1'b0;
    measure(16, "R3 gate open");
    gate_en = 1'b0; gate_n = 1'b1;
    measure(16, "R3 gate ignored");

    // R2: run off
    run = 1'b0;
    quiet(1500, "R2 run off");
    run = 1'b1; src = 1'b0; reload = 8'hFE;
    measure(2 * 6, "R2 R4 resumed");

    // R1: reset mid-run clears the tick
    rst_n = 1'b0;
    @(negedge clk);
    check(tick == 1'b0, "R1 reset mid-run", int'(tick), 0);
    rst_n = 1'b1;
    measure(2 * 6, "R1 R6 after reset");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule